// File: doc/BRIEF.md
# Emulator Break and Memory Steering Controller

This controller sits between an emulation processor, the bus of the target system and a small private shadow memory. It decides when the processor leaves the user program and enters the debug kernel. It arbitrates break requests from three sources: a host command, a trigger unit and the receive interrupt of a serial port. On an accepted break it pulses the processor's non-maskable interrupt (NMI). It stops the target's own NMI from reaching the processor, and it turns the target bus buffers off.

While the controller is out of run mode, every processor access is steered into shadow memory. The lower part of shadow space is read-only ROM that holds the debugger entry vector and the kernel. The upper part is RAM for the kernel's working data. Steering changes in the same cycle that the NMI rises and stays changed for as long as the NMI is held, so the vector fetch cannot reach target memory. The debug kernel ends the session with a resume strobe. This brings back the target buffers and lets the target NMI through again.

Top module: `emu_break_ctrl`

## Requirements
- R1: After reset `mode_o` is 2'b00 (run), `ovf_o` is 0 and `brk_src_o` is 0. In run mode `nmi_o` equals `tgt_nmi_i` in the same cycle, and `tgt_buf_en_o` is 1.
- R2: If any break input is high at a rising clock edge in run mode, then after that edge `mode_o` is 2'b01 (break pending), `nmi_o` is 1 and `tgt_buf_en_o` is 0.
- R3: `nmi_o` stays high for exactly NMI_HOLD cycles of break pending. After that `mode_o` is 2'b10 (debug) and `nmi_o` is 0. `tgt_buf_en_o` stays 0 throughout.
- R4: Outside the break-pending pulse, `tgt_nmi_i` has no effect on `nmi_o` while the mode is not run.
- R5: When the mode is not run, a read at an address below ROM_LIMIT asserts only `shd_rom_cs_o`. A read at ROM_LIMIT or above asserts only `shd_ram_cs_o`. With no read or write, neither select is asserted.
- R6: When the mode is not run, a write below ROM_LIMIT asserts no shadow select. A write at ROM_LIMIT or above asserts `shd_ram_cs_o` and `shd_ram_we_o`.
- R7: In run mode no read or write asserts any shadow select or `shd_ram_we_o`.
- R8: `resume_i` high at an edge in debug mode returns `mode_o` to 2'b00 after that edge. `resume_i` has no effect in run or break-pending mode.
- R9: A break input that is high at an edge in break-pending or debug mode leaves the mode, the NMI timing and `brk_src_o` unchanged. It sets `ovf_o` to 1, and `ovf_o` then stays 1 until reset.
- R10: When several break inputs are high at once, the host request wins over the trigger, and the trigger wins over serial receive. `brk_src_o` holds the accepted source one-hot (bit 0 host, bit 1 trigger, bit 2 serial) until the next accepted break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_brk_i | input | 1 | Break request from host command |
| trig_brk_i | input | 1 | Break request from trigger unit |
| uart_rx_irq_i | input | 1 | Break request from serial receive interrupt |
| resume_i | input | 1 | Resume strobe from debug kernel |
| tgt_nmi_i | input | 1 | NMI from the target system |
| cpu_addr_i | input | ADDR_W | Processor address |
| cpu_rd_i | input | 1 | Processor read strobe |
| cpu_wr_i | input | 1 | Processor write strobe |
| nmi_o | output | 1 | NMI to the processor |
| tgt_buf_en_o | output | 1 | Target address/data buffer enable |
| shd_rom_cs_o | output | 1 | Shadow ROM select |
| shd_ram_cs_o | output | 1 | Shadow RAM select |
| shd_ram_we_o | output | 1 | Shadow RAM write enable |
| mode_o | output | 2 | Mode: 00 run, 01 break pending, 10 debug |
| brk_src_o | output | 3 | One-hot source of last accepted break |
| ovf_o | output | 1 | Sticky flag for ignored break requests |

## Verification
The bench builds the controller with a 12-bit address, a ROM boundary at 0x100 and an NMI hold of 3 cycles. A short address makes it cheap to drive both sides of the ROM/RAM boundary, including the first address above the boundary and the last one below it. A hold of 3 leaves room for a break request in the middle of the pulse, so the bench can check that such a request does not stretch or restart the pulse.

// File: rtl/emu_break_pkg.sv
// Shared types for the break/steering controller.
// Assumes: two-bit mode encoding; the encoding is visible on mode_o.
package emu_break_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_PEND = 2'b01,
        MODE_DBG  = 2'b10
    } emu_mode_e;

    localparam int unsigned NUM_BRK_SRC = 3;
endpackage

// File: rtl/brk_arbiter.sv
// Fixed-priority break arbiter: bit 0 has the highest priority.
// It records the accepted source and a sticky flag for requests made while
// no break can be accepted.
// Assumes: the requests are synchronous to clk; accept_en_i is high only in run mode.
module brk_arbiter #(
    parameter int unsigned NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            accept_en_i,
    output logic            take_o,
    output logic [NSRC-1:0] src_q_o,
    output logic            ovf_o
);
    logic [NSRC:0]   seen;
    logic [NSRC-1:0] grant;

    assign seen[0] = 1'b0;
    // priority chain: each request is granted only if no lower index requests
    for (genvar gi = 0; gi < NSRC; gi++) begin : g_prio
        assign grant[gi]  = req_i[gi] & ~seen[gi];
        assign seen[gi+1] = seen[gi] | req_i[gi];
    end

    assign take_o = seen[NSRC] & accept_en_i;

    // capture the winning source on each accepted break
    always_ff @(posedge clk) begin
        if (!rst_n)      src_q_o <= '0;
        else if (take_o) src_q_o <= grant;
    end

    // sticky flag for requests that arrive while a break is in progress
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovf_o <= 1'b0;
        else if (seen[NSRC] && !accept_en_i) ovf_o <= 1'b1;
    end

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    assert_src_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_q_o));
    assert_src_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_en_i |=> $stable(src_q_o));
endmodule

// File: rtl/mode_fsm.sv
// Mode sequencer: run -> break pending (NMI pulse) -> debug -> run.
// The pending state lasts exactly NMI_HOLD cycles.
// Assumes: NMI_HOLD >= 1; resume_i is a strobe from the debug kernel.
module mode_fsm
    import emu_break_pkg::*;
#(
    parameter int unsigned NMI_HOLD = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      take_i,
    input  logic      resume_i,
    output emu_mode_e mode_o,
    output logic      pulse_o
);
    localparam int unsigned CW = (NMI_HOLD < 2) ? 1 : $clog2(NMI_HOLD);
    localparam logic [CW-1:0] LAST = CW'(NMI_HOLD - 1);

    emu_mode_e     mode_q, mode_d;
    logic [CW-1:0] cnt_q;

    // next-state selection
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN:  if (take_i)        mode_d = MODE_PEND;
            MODE_PEND: if (cnt_q == LAST) mode_d = MODE_DBG;
            MODE_DBG:  if (resume_i)      mode_d = MODE_RUN;
            default:                      mode_d = MODE_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    // pulse-length counter, cleared outside the pending state
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (mode_q == MODE_PEND) cnt_q <= cnt_q + 1'b1;
        else                         cnt_q <= '0;
    end

    assign mode_o  = mode_q;
    assign pulse_o = (mode_q == MODE_PEND);

    assert_enter_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN && take_i) |=> mode_q == MODE_PEND);
    assert_hold_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PEND) |-> (int'(cnt_q) < NMI_HOLD));
    assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DBG && resume_i) |=> mode_q == MODE_RUN);
    assert_no_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN) |=> mode_q != MODE_DBG);
endmodule

// File: rtl/mem_steer.sv
// NMI gating and memory steering. In run mode the target buffers are on and
// the target NMI passes through. Out of run mode the buffers are off and
// accesses are decoded into shadow ROM (below ROM_LIMIT, read only) and
// shadow RAM.
// Assumes: ROM_LIMIT fits within ADDR_W bits; clk/rst_n serve the checks only.
module mem_steer #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned ROM_LIMIT = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shadow_i,
    input  logic              pulse_i,
    input  logic              tgt_nmi_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output logic              nmi_o,
    output logic              tgt_buf_en_o,
    output logic              rom_cs_o,
    output logic              ram_cs_o,
    output logic              ram_we_o
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(ROM_LIMIT);

    logic in_rom;

    // NMI: local pulse, or target NMI only while running user code
    always_comb nmi_o = pulse_i | (~shadow_i & tgt_nmi_i);

    // region decode and select generation
    always_comb begin
        in_rom       = (addr_i < LIMIT);
        tgt_buf_en_o = ~shadow_i;
        rom_cs_o     = shadow_i & rd_i & in_rom;
        ram_cs_o     = shadow_i & (rd_i | wr_i) & ~in_rom;
        ram_we_o     = shadow_i & wr_i & ~in_rom;
    end

    assert_buf_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |-> !tgt_buf_en_o);
    assert_nmi_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_i && !pulse_i) |-> !nmi_o);
    assert_cs_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs_o, ram_cs_o}));
    assert_rom_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> !rom_cs_o);
    assert_run_no_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shadow_i |-> !(rom_cs_o || ram_cs_o || ram_we_o));
endmodule

// File: rtl/emu_break_ctrl.sv
// Top level: break arbitration, mode sequencing and memory steering for an
// emulation processor.
// Assumes: all inputs are synchronous to clk; resume_i comes from the debug kernel.
module emu_break_ctrl
    import emu_break_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned ROM_LIMIT = 16'h4000,
    parameter int unsigned NMI_HOLD  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_brk_i,
    input  logic              trig_brk_i,
    input  logic              uart_rx_irq_i,
    input  logic              resume_i,
    input  logic              tgt_nmi_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              cpu_rd_i,
    input  logic              cpu_wr_i,
    output logic              nmi_o,
    output logic              tgt_buf_en_o,
    output logic              shd_rom_cs_o,
    output logic              shd_ram_cs_o,
    output logic              shd_ram_we_o,
    output logic [1:0]        mode_o,
    output logic [2:0]        brk_src_o,
    output logic              ovf_o
);
    emu_mode_e                mode;
    logic                     take;
    logic                     pulse;
    logic                     shadow;
    logic [NUM_BRK_SRC-1:0]   req;
    logic [NUM_BRK_SRC-1:0]   src_q;

    assign req    = {uart_rx_irq_i, trig_brk_i, host_brk_i};
    assign shadow = (mode != MODE_RUN);

    brk_arbiter #(.NSRC(NUM_BRK_SRC)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .accept_en_i (~shadow),
        .take_o      (take),
        .src_q_o     (src_q),
        .ovf_o       (ovf_o)
    );

    mode_fsm #(.NMI_HOLD(NMI_HOLD)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .resume_i (resume_i),
        .mode_o   (mode),
        .pulse_o  (pulse)
    );

    mem_steer #(.ADDR_W(ADDR_W), .ROM_LIMIT(ROM_LIMIT)) u_steer (
        .clk          (clk),
        .rst_n        (rst_n),
        .shadow_i     (shadow),
        .pulse_i      (pulse),
        .tgt_nmi_i    (tgt_nmi_i),
        .addr_i       (cpu_addr_i),
        .rd_i         (cpu_rd_i),
        .wr_i         (cpu_wr_i),
        .nmi_o        (nmi_o),
        .tgt_buf_en_o (tgt_buf_en_o),
        .rom_cs_o     (shd_rom_cs_o),
        .ram_cs_o     (shd_ram_cs_o),
        .ram_we_o     (shd_ram_we_o)
    );

    assign mode_o    = mode;
    assign brk_src_o = src_q;

    assert_run_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |-> (nmi_o == tgt_nmi_i && tgt_buf_en_o));
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && !resume_i) |=> mode_o == 2'b10);
endmodule

// File: tb/sim_emu_break_ctrl.sv
`timescale 1ns/1ps
module sim_emu_break_ctrl;
    localparam int unsigned AW   = 12;
    localparam int unsigned LIM  = 12'h100;
    localparam int unsigned HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host = 0, trig = 0, uart = 0, resume = 0, tnmi = 0, rd = 0, wr = 0;
    logic [AW-1:0] addr = '0;
    logic nmi, buf_en, rom_cs, ram_cs, ram_we, ovf;
    logic [1:0] mode;
    logic [2:0] src;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    emu_break_ctrl #(.ADDR_W(AW), .ROM_LIMIT(LIM), .NMI_HOLD(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .host_brk_i(host), .trig_brk_i(trig),
        .uart_rx_irq_i(uart), .resume_i(resume), .tgt_nmi_i(tnmi),
        .cpu_addr_i(addr), .cpu_rd_i(rd), .cpu_wr_i(wr), .nmi_o(nmi),
        .tgt_buf_en_o(buf_en), .shd_rom_cs_o(rom_cs), .shd_ram_cs_o(ram_cs),
        .shd_ram_we_o(ram_we), .mode_o(mode), .brk_src_o(src), .ovf_o(ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // drive a break on the selected sources for one edge
    task automatic pulse_brk(input logic [2:0] s);
        {uart, trig, host} = s;
        step();
        {uart, trig, host} = 3'b000;
    endtask

    task automatic go_debug(input logic [2:0] s);
        pulse_brk(s);
        repeat (HOLD) step();
    endtask

    task automatic back_to_run();
        resume = 1;
        step();
        resume = 0;
    endtask

    task automatic t_reset();
        chk("R1 reset mode", mode, 2'b00);
        chk("R1 reset ovf", ovf, 0);
        chk("R1 reset src", src, 3'b000);
        chk("R1 reset buf", buf_en, 1);
    endtask

    task automatic t_run_passthru();
        tnmi = 1; #0.5;
        chk("R1 nmi passes", nmi, 1);
        tnmi = 0; #0.5;
        chk("R1 nmi low", nmi, 0);
        rd = 1; addr = 12'h010; #0.5;
        chk("R7 run rom read", {rom_cs, ram_cs}, 2'b00);
        rd = 0; wr = 1; addr = 12'h200; #0.5;
        chk("R7 run ram write", {ram_cs, ram_we}, 2'b00);
        wr = 0;
        resume = 1; step(); resume = 0;
        chk("R8 resume in run ignored", mode, 2'b00);
    endtask

    task automatic t_break_entry();
        pulse_brk(3'b001);
        chk("R2 mode pending", mode, 2'b01);
        chk("R2 nmi high", nmi, 1);
        chk("R2 buf off", buf_en, 0);
        chk("R10 src host", src, 3'b001);
        resume = 1;
        for (int i = 1; i < HOLD; i++) begin
            step();
            resume = 0;
            chk("R3 nmi still high", nmi, 1);
            chk("R8 resume in pending ignored", mode, 2'b01);
        end
        resume = 0;
        step();
        chk("R3 mode debug", mode, 2'b10);
        chk("R3 nmi released", nmi, 0);
        chk("R3 buf still off", buf_en, 0);
        tnmi = 1; #0.5;
        chk("R4 target nmi blocked", nmi, 0);
        tnmi = 0;
    endtask

    task automatic t_shadow_decode();
        rd = 1; addr = LIM - 1; #0.5;
        chk("R5 rom read top", {rom_cs, ram_cs}, 2'b10);
        addr = LIM; #0.5;
        chk("R5 ram read base", {rom_cs, ram_cs}, 2'b01);
        addr = 12'h000; #0.5;
        chk("R5 vector read", {rom_cs, ram_cs}, 2'b10);
        rd = 0; #0.5;
        chk("R5 idle", {rom_cs, ram_cs}, 2'b00);
        wr = 1; addr = 12'h020; #0.5;
        chk("R6 rom write suppressed", {rom_cs, ram_cs, ram_we}, 3'b000);
        addr = 12'hFFF; #0.5;
        chk("R6 ram write", {rom_cs, ram_cs, ram_we}, 3'b011);
        wr = 0;
    endtask

    task automatic t_overflow();
        chk("R9 ovf clear before", ovf, 0);
        pulse_brk(3'b010);
        chk("R9 debug kept", mode, 2'b10);
        chk("R9 ovf set", ovf, 1);
        chk("R9 src unchanged", src, 3'b001);
        back_to_run();
        chk("R8 resume to run", mode, 2'b00);
        chk("R9 ovf sticky", ovf, 1);
        // request mid-pulse must not stretch it
        pulse_brk(3'b100);
        uart = 1; step(); uart = 0;
        chk("R9 pending kept", mode, 2'b01);
        repeat (HOLD - 1) step();
        chk("R9 pulse not stretched", {mode, nmi}, {2'b10, 1'b0});
        chk("R9 src serial kept", src, 3'b100);
        back_to_run();
    endtask

    task automatic t_priority();
        go_debug(3'b111);
        chk("R10 host wins", src, 3'b001);
        back_to_run();
        go_debug(3'b110);
        chk("R10 trigger over serial", src, 3'b010);
        back_to_run();
        chk("R10 src held in run", src, 3'b010);
        go_debug(3'b100);
        chk("R10 serial alone", src, 3'b100);
        back_to_run();
        chk("R8 final run", {mode, buf_en}, {2'b00, 1'b1});
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_run_passthru();
        t_break_entry();
        t_shadow_decode();
        t_overflow();
        t_priority();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule